// File: doc/BRIEF.md
# Carry-Preserving Integer ALU

This block is a 32-bit integer arithmetic unit with a registered status-flag word. Each cycle it takes an opcode and two operands, and it computes a result and the proposed next flags as pure logic from those inputs and the current flag register. When the valid strobe is high, the flag register loads the proposed flags on the rising clock edge.

The defining property is a partial flag update. Increment and decrement rewrite zero, sign, parity and overflow but hold the carry bit. Software can therefore step a loop counter between the words of a multi-word addition, or between rotate-through-carry steps, and the pending carry survives. Add, add-with-carry and subtract write every flag, carry included. A caller that needs a carry or borrow from a step of one uses those operations with an operand of 1.

Top module: `flag_keep_alu`

## Requirements
- R1: Opcode encoding on `op`: 0 increment (a+1), 1 decrement (a-1), 2 add (a+b), 3 add-with-carry (a+b+C), 4 subtract (a-b), 5 rotate right through carry. All results wrap modulo 2^32.
- R2: Flag word bit positions are C=bit0, Z=bit1, S=bit2, P=bit3, V=bit4. Increment, decrement, add, add-with-carry and subtract set Z when the result is zero. They copy result bit 31 into S. They set P when the low 8 result bits hold an even number of ones.
- R3: Increment and decrement leave C equal to its value in the flag register.
- R4: Add and add-with-carry put the carry out of bit 31 into C. Subtract puts the borrow (a < b, unsigned) into C.
- R5: Rotate right through carry returns {C, a[31:1]} and puts a[0] into C. Z, S, P and V are unchanged.
- R6: Incrementing 0xFFFFFFFF gives 0 with Z=1. Decrementing 0 gives 0xFFFFFFFF with S=1 and Z=0. C is held in both cases.
- R7: V is set on signed two's-complement overflow for increment, decrement, add, add-with-carry and subtract.
- R8: The flag register loads `flags_next` on a rising edge only while `valid` is high. A synchronous reset clears it to 0.
- R9: Opcodes 6 and 7 return `a` unchanged and propose the current flags unchanged.
- R10: An add of the low words, then a decrement of an unrelated counter, then an add-with-carry of the high words gives the correct 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Commit `flags_next` into the flag register this cycle |
| op | input | 3 | Operation select |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Operation result (combinational) |
| flags_next | output | 5 | Proposed next flag word (combinational) |
| flags | output | 5 | Registered flag word |

## Verification
Two functions can fall in the same cycle. One is the carry being held by an increment or decrement. The other is the carry being consumed by the next add-with-carry or rotate, which reads a C that was written two operations earlier. The bench provokes this directly with a 64-bit add split around a counter decrement, and with rotates placed right after increments. Random sequences also mix all opcodes and leave the strobe low on some cycles. The result, the proposed flags and the committed register are each compared with a model flag word that the bench carries forward on its own.

// File: rtl/flag_keep_alu.sv
module flag_keep_alu #(
  parameter int W  = 32,
  parameter int PW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic [4:0]   flags_next,
  output logic [4:0]   flags
);
  localparam int FC = 0, FZ = 1, FS = 2, FP = 3, FV = 4;
  localparam logic [2:0] OP_INC = 3'd0, OP_DEC = 3'd1, OP_ADD = 3'd2,
                         OP_ADC = 3'd3, OP_SUB = 3'd4, OP_RCR = 3'd5;
  localparam logic [W-1:0] ONE    = W'(1);
  localparam logic [W-1:0] MIN_S  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_S  = ~MIN_S;

  logic         cin;
  logic [W:0]   add_w, sub_w;
  logic [W-1:0] r;
  logic         c_n, v_n, arith;

  assign cin   = flags[FC];
  assign add_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (op == OP_ADC) & cin};
  assign sub_w = {1'b0, a} - {1'b0, b};

  always_comb begin
    r     = a;
    c_n   = cin;
    v_n   = flags[FV];
    arith = 1'b0;
    case (op)
      OP_INC: begin
        r = a + ONE; v_n = (a == MAX_S); arith = 1'b1;
      end
      OP_DEC: begin
        r = a - ONE; v_n = (a == MIN_S); arith = 1'b1;
      end
      OP_ADD, OP_ADC: begin
        r = add_w[W-1:0]; c_n = add_w[W]; arith = 1'b1;
        v_n = (a[W-1] == b[W-1]) && (add_w[W-1] != a[W-1]);
      end
      OP_SUB: begin
        r = sub_w[W-1:0]; c_n = sub_w[W]; arith = 1'b1;
        v_n = (a[W-1] != b[W-1]) && (sub_w[W-1] != a[W-1]);
      end
      OP_RCR: begin
        r = {cin, a[W-1:1]}; c_n = a[0];
      end
      default: ;
    endcase
  end

  assign result         = r;
  assign flags_next[FC] = c_n;
  assign flags_next[FV] = v_n;
  assign flags_next[FZ] = arith ? (r == '0)     : flags[FZ];
  assign flags_next[FS] = arith ? r[W-1]        : flags[FS];
  assign flags_next[FP] = arith ? ~^r[PW-1:0]   : flags[FP];

  always_ff @(posedge clk) begin
    if (rst)        flags <= '0;
    else if (valid) flags <= flags_next;
  end
endmodule

// File: rtl/flag_keep_alu_chk.sv
module flag_keep_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         valid,
  input logic [2:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] result,
  input logic [4:0]   flags
);
  a_r3_incdec_hold_carry: assert property (@(posedge clk) disable iff (rst)
    (valid && (op == 3'd0 || op == 3'd1)) |=> (flags[0] == $past(flags[0])));

  a_r5_rotate_carry_out: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 3'd5) |=> (flags[0] == $past(a[0])));

  a_r8_hold_without_valid: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(flags));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == 5'd0));

  a_r2_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
    (valid && op <= 3'd4) |=> (flags[1] == ($past(result) == '0)));

  a_r6_inc_wrap: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 && a == '1) |-> (result == '0));
endmodule

bind flag_keep_alu flag_keep_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .op(op), .a(a),
  .result(result), .flags(flags)
);

// File: tb/flag_keep_alu_tb.sv
`timescale 1ns/1ps
module flag_keep_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic [4:0]  flags_next, flags;
  logic [4:0]  mflags = '0;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  flag_keep_alu u_dut (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .a(a), .b(b),
    .result(result), .flags_next(flags_next), .flags(flags)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [36:0] ref_op(input logic [2:0] o, input logic [31:0] x,
                                         input logic [31:0] y, input logic [4:0] f);
    logic [31:0] r;
    logic [4:0]  nf;
    longint      sv;
    longint unsigned uv;
    bit          ar;
    nf = f; r = x; ar = 0;
    case (o)
      3'd0: begin r = x + 32'd1; ar = 1; nf[4] = (x == 32'h7fffffff); end
      3'd1: begin r = x - 32'd1; ar = 1; nf[4] = (x == 32'h80000000); end
      3'd2, 3'd3: begin
        uv = longint'(x) + longint'(y) + ((o == 3'd3) ? longint'(f[0]) : 0);
        sv = longint'($signed(x)) + longint'($signed(y)) + ((o == 3'd3) ? longint'(f[0]) : 0);
        r = uv[31:0]; nf[0] = uv[32]; ar = 1;
        nf[4] = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      3'd4: begin
        sv = longint'($signed(x)) - longint'($signed(y));
        r = x - y; nf[0] = (x < y); ar = 1;
        nf[4] = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      3'd5: begin r = {f[0], x[31:1]}; nf[0] = x[0]; end
      default: ;
    endcase
    if (ar) begin
      nf[1] = (r == 32'd0);
      nf[2] = r[31];
      nf[3] = ($countones(r[7:0]) % 2) == 0;
    end
    return {nf, r};
  endfunction

  function automatic string rtag(input logic [2:0] o);
    if (o == 3'd5) return "R5";
    if (o > 3'd5)  return "R9";
    return "R1";
  endfunction

  function automatic string ftag(input logic [2:0] o);
    if (o <= 3'd1) return "R3 R2 R7";
    if (o <= 3'd4) return "R4 R2 R7";
    if (o == 3'd5) return "R5";
    return "R9";
  endfunction

  task automatic do_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic v, input string tr, input string tf,
                       output logic [31:0] res);
    logic [36:0] e;
    @(negedge clk);
    op = o; a = x; b = y; valid = v;
    #1;
    e = ref_op(o, x, y, mflags);
    check(tr, {32'd0, result}, {32'd0, e[31:0]});
    check(tf, {59'd0, flags_next}, {59'd0, e[36:32]});
    res = result;
    @(posedge clk);
    #1;
    if (v) mflags = e[36:32];
    check("R8", {59'd0, flags}, {59'd0, mflags});
    valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rl, rh, rx;
    logic [63:0] p, q;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset", {59'd0, flags}, 64'd0);
    @(negedge clk); rst = 1'b0;

    do_op(3'd2, 32'hffffffff, 32'd1, 1, "R1", "R4", rx);
    do_op(3'd0, 32'hffffffff, 32'd0, 1, "R6", "R6 R3", rx);
    do_op(3'd1, 32'd0, 32'd0, 1, "R6", "R6 R3", rx);
    do_op(3'd5, 32'h0000_0002, 32'd0, 1, "R5", "R5", rx);
    do_op(3'd0, 32'h7fffffff, 32'd0, 1, "R1", "R7", rx);
    do_op(3'd1, 32'h80000000, 32'd0, 1, "R1", "R7", rx);
    do_op(3'd4, 32'd3, 32'd5, 1, "R1", "R4", rx);
    do_op(3'd0, 32'd41, 32'd0, 1, "R1", "R3", rx);
    do_op(3'd5, 32'h1234_5679, 32'd0, 1, "R5", "R5", rx);
    do_op(3'd6, 32'hdead_beef, 32'd7, 1, "R9", "R9", rx);
    do_op(3'd7, 32'h0000_0000, 32'd7, 1, "R9", "R9", rx);
    do_op(3'd2, 32'h8000_0000, 32'h8000_0000, 0, "R1", "R4", rx);

    for (int k = 0; k < 20; k++) begin
      p = {$urandom(), 16'hffff, 16'($urandom())};
      q = {$urandom(), $urandom()};
      do_op(3'd2, p[31:0], q[31:0], 1, "R10", "R10", rl);
      do_op(3'd1, 32'($urandom() % 4), 32'd0, 1, "R10", "R10 R3", rx);
      do_op(3'd3, p[63:32], q[63:32], 1, "R10", "R10", rh);
      check("R10 sum", {rh, rl}, p + q);
    end

    for (int k = 0; k < 3000; k++) begin
      logic [2:0]  o;
      logic [31:0] x, y;
      o = 3'($urandom() % 8);
      case ($urandom() % 6)
        0: x = 32'hffffffff;
        1: x = 32'd0;
        2: x = 32'h7fffffff;
        3: x = 32'h80000000;
        default: x = $urandom();
      endcase
      y = ($urandom() % 4 == 0) ? x : $urandom();
      do_op(o, x, y, ($urandom() % 4) != 0, rtag(o), ftag(o), rx);
      if (k == 1500) begin
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R8 reset", {59'd0, flags}, 64'd0);
        mflags = '0;
        @(negedge clk); rst = 1'b0;
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule